// File: doc/BRIEF.md
# Block-Length SPI Master with Word FIFO

This block is an SPI master that a processor drives through a small register bus. Software first writes a byte count into the length register. It then writes the control register with a clock rate code, a chip-select number, a direction and the start bit. After that it moves 32-bit words through the data register. In the send direction the bytes of each word leave the FIFO on MOSI. In the receive direction the bytes seen on MISO are packed into words that software reads back. The last word of a block may hold fewer than four valid bytes.

The chip select chosen at start stays asserted after the block completes. A command block can therefore be followed by a data block under the same select. The select is released only when software writes the done register. A flag in the status register applies back-pressure on the data path. In the send direction it means the FIFO is full, and in the receive direction it means the FIFO is empty. Software tests this flag before moving a word. The end of a transfer raises an interrupt, which has its own mask and a write-one-to-clear status bit.

Top module: `spim_master`

## Requirements
- R1: After reset all chip selects are high, SCK is low, irq is low, the control register reads 0 and status bit 0 reads 1.
- R2: Register offsets are control 0x00, done 0x04, length 0x08, data 0x0C, status 0x10, interrupt mask 0x18 and interrupt status 0x1C. Control bits [2:0] hold the rate code, bits [7:6] the chip-select number, bit 13 the direction (1 = send) and bit 15 start/busy. The length register keeps 21 bits, so a write of all ones reads back 0x1FFFFF.
- R3: In the send direction exactly length bytes go out. Byte 0 is bits [7:0] of the first FIFO word, each byte is sent MSB first, and SPI mode 0 is used: MOSI changes while SCK is low and is sampled on the rising edge.
- R4: In the receive direction MOSI stays 0 and the MISO bytes are packed little-endian into ceil(length/4) words. The unused bytes of the last word read as 0.
- R5: SCK high and low phases each last DIV_BASE>>code cycles, with codes 6 and 7 treated as 5 and a minimum of 1 cycle. With DIV_BASE=32, codes 3, 4 and 5 give 4, 2 and 1 cycles.
- R6: From the edge that takes the start, the selected chip select, and only that one, is low. It stays low after the block ends and across later blocks.
- R7: A write to the done register while idle raises every chip select on the next edge. A done write during a transfer is deferred until the transfer ends. The release then comes at least one half SCK period after the last SCK fall.
- R8: Status bit 0 reads 1 when the FIFO is full in the send direction and when it is empty in the receive direction. The FIFO holds 8 words, and a start clears it.
- R9: Control bit 15 reads 1 from the edge after the start until the transfer ends. A start written while the block is busy is ignored.
- R10: The end of a transfer sets interrupt status bit 0. irq equals that bit AND NOT mask bit 0. Writing 1 to status bit 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe (a read of the data register pops the FIFO) |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the address |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Master data out |
| spi_miso | input | 1 | Master data in |
| spi_cs_n | output | NCS | Active-low chip selects |
| irq | output | 1 | Transfer-end interrupt |

## Verification
Register reads are combinational and are valid in the cycle the address is presented. Register writes take effect at the next edge, so the bench samples every result at the falling edge that follows its bus task. A done write while idle lifts the selects after one edge. The busy bit and the interrupt change one edge after the trailing half period of the last byte. Each byte takes seventeen half periods. Rather than counting byte times, the bench polls the busy and FIFO flags and compares what the bus returns and what its SPI slave model captured against values from its own functions. The high time of SCK is measured in clock periods to check the rate codes.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam logic [4:0] A_CTRL  = 5'h00;
  localparam logic [4:0] A_DONE  = 5'h04;
  localparam logic [4:0] A_LEN   = 5'h08;
  localparam logic [4:0] A_FIFO  = 5'h0C;
  localparam logic [4:0] A_STAT  = 5'h10;
  localparam logic [4:0] A_IMASK = 5'h18;
  localparam logic [4:0] A_ISTAT = 5'h1C;

  localparam int CB_DIR   = 13;
  localparam int CB_START = 15;
  localparam int CS_LSB   = 6;

  typedef enum logic [1:0] {E_IDLE, E_FEED, E_WAIT} eng_t;
endpackage

// File: rtl/spim_rate.sv
module spim_rate #(
  parameter int DIV_BASE = 32,
  parameter int RW       = 3,
  parameter int MAX_CODE = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [RW-1:0] code,
  output logic          tick
);
  localparam int CW = $clog2(DIV_BASE + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] half;

  always_comb begin
    logic [RW-1:0] ce;
    ce = (code > RW'(MAX_CODE)) ? RW'(MAX_CODE) : code;
    half = CW'(DIV_BASE >> ce);
    if (half == '0) half = CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (!run)                 cnt <= '0;
    else if (cnt == half - CW'(1)) cnt <= '0;
    else                           cnt <= cnt + CW'(1);
  end

  assign tick = run && (cnt == half - CW'(1));
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [BITS-1:0] tx,
  input  logic            tick,
  input  logic            miso,
  output logic            sck,
  output logic            mosi,
  output logic            busy,
  output logic            done,
  output logic [BITS-1:0] rx
);
  localparam int LAST = 2 * BITS;
  localparam int PW   = $clog2(LAST + 1);

  logic [PW-1:0]   ph;
  logic [BITS-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sck  <= 1'b0;
      ph   <= '0;
      sr   <= '0;
      rx   <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;
        sr   <= tx;
        ph   <= '0;
        sck  <= 1'b0;
      end else if (busy && tick) begin
        ph <= ph + PW'(1);
        if (ph == PW'(LAST)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else if (!ph[0]) begin
          sck <= 1'b1;
          rx  <= {rx[BITS-2:0], miso};
        end else begin
          sck <= 1'b0;
          sr  <= {sr[BITS-2:0], 1'b0};
        end
      end
    end
  end

  assign mosi = busy & sr[BITS-1];
endmodule

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  wire do_push = push && !full;
  wire do_pop  = pop && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (do_pop)  rp <= rp + AW'(1);
      if (do_push && !do_pop)      cnt <= cnt + (AW+1)'(1);
      else if (do_pop && !do_push) cnt <= cnt - (AW+1)'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= wdata;
  end

  assign rdata = mem[rp];
  assign full  = (cnt == (AW+1)'(DEPTH));
  assign empty = (cnt == '0);
endmodule

// File: rtl/spim_master.sv
module spim_master
  import spim_pkg::*;
#(
  parameter int NCS        = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_BASE   = 32,
  parameter int LEN_W      = 21,
  parameter int WORD_W     = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [4:0]     bus_addr,
  input  logic           bus_wr,
  input  logic [31:0]    bus_wdata,
  input  logic           bus_rd,
  output logic [31:0]    bus_rdata,
  output logic           spi_sck,
  output logic           spi_mosi,
  input  logic           spi_miso,
  output logic [NCS-1:0] spi_cs_n,
  output logic           irq
);
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1;
  localparam int BPW = WORD_W / 8;
  localparam int BIW = $clog2(BPW);

  eng_t             st;
  logic             busy, dir_wr, cs_act, done_pend, mask_q, istat;
  logic [2:0]       rate_q;
  logic [CSW-1:0]   cs_q;
  logic [LEN_W-1:0] len_q, remain;
  logic [BIW-1:0]   bidx;
  logic [WORD_W-1:0] hold, acc, acc_nx;

  logic             fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [WORD_W-1:0] fifo_wdata, fifo_rdata;
  logic             sh_start, sh_busy, sh_done, tick;
  logic [7:0]       sh_tx, sh_rx;

  wire wr_ctrl  = bus_wr && bus_addr == A_CTRL;
  wire wr_done  = bus_wr && bus_addr == A_DONE;
  wire wr_len   = bus_wr && bus_addr == A_LEN;
  wire wr_fifo  = bus_wr && bus_addr == A_FIFO;
  wire wr_mask  = bus_wr && bus_addr == A_IMASK;
  wire wr_istat = bus_wr && bus_addr == A_ISTAT;
  wire rd_fifo  = bus_rd && bus_addr == A_FIFO;

  wire start_req = wr_ctrl && bus_wdata[CB_START] && !busy;
  wire last_byte = (remain == LEN_W'(1));

  logic unused_bits;
  assign unused_bits = &{1'b0, bus_wdata[31:LEN_W]};

  // byte engine feed decision
  logic feed_go;
  always_comb begin
    feed_go = 1'b0;
    if (st == E_FEED)
      feed_go = dir_wr ? (bidx != '0 || !fifo_empty)
                       : (bidx != '0 || !fifo_full);
  end

  always_comb begin
    sh_tx = 8'h00;
    if (dir_wr)
      sh_tx = (bidx == '0) ? fifo_rdata[7:0] : hold[{bidx, 3'b000} +: 8];
  end
  assign sh_start = feed_go;

  always_comb begin
    acc_nx = acc;
    acc_nx[{bidx, 3'b000} +: 8] = sh_rx;
  end

  wire eng_pop  = feed_go && dir_wr && bidx == '0;
  wire eng_push = st == E_WAIT && sh_done && !dir_wr &&
                  (bidx == BIW'(BPW - 1) || last_byte);
  wire bus_push = wr_fifo && dir_wr && !fifo_full;
  wire bus_pop  = rd_fifo && !dir_wr && !fifo_empty;

  assign fifo_push  = bus_push | eng_push;
  assign fifo_pop   = bus_pop | eng_pop;
  assign fifo_wdata = dir_wr ? bus_wdata[WORD_W-1:0] : acc_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= E_IDLE;
      busy      <= 1'b0;
      dir_wr    <= 1'b0;
      rate_q    <= '0;
      cs_q      <= '0;
      cs_act    <= 1'b0;
      done_pend <= 1'b0;
      len_q     <= '0;
      remain    <= '0;
      bidx      <= '0;
      hold      <= '0;
      acc       <= '0;
      mask_q    <= 1'b0;
      istat     <= 1'b0;
    end else begin
      if (wr_len)   len_q  <= bus_wdata[LEN_W-1:0];
      if (wr_mask)  mask_q <= bus_wdata[0];
      if (wr_istat && bus_wdata[0]) istat <= 1'b0;
      if (wr_done) begin
        if (busy) done_pend <= 1'b1;
        else      cs_act    <= 1'b0;
      end
      if (start_req) begin
        dir_wr <= bus_wdata[CB_DIR];
        rate_q <= bus_wdata[2:0];
        cs_q   <= bus_wdata[CS_LSB +: CSW];
        cs_act <= 1'b1;
        remain <= len_q;
        bidx   <= '0;
        acc    <= '0;
        if (len_q == '0) istat <= 1'b1;
        else begin
          busy <= 1'b1;
          st   <= E_FEED;
        end
      end
      case (st)
        E_FEED: begin
          if (feed_go) begin
            st <= E_WAIT;
            if (dir_wr && bidx == '0)  hold <= fifo_rdata;
            if (!dir_wr && bidx == '0) acc  <= '0;
          end
        end
        E_WAIT: begin
          if (sh_done) begin
            remain <= remain - LEN_W'(1);
            bidx   <= bidx + BIW'(1);
            if (!dir_wr) acc <= acc_nx;
            if (last_byte) begin
              busy  <= 1'b0;
              istat <= 1'b1;
              st    <= E_IDLE;
              if (done_pend || wr_done) begin
                cs_act    <= 1'b0;
                done_pend <= 1'b0;
              end
            end else begin
              st <= E_FEED;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[2:0]             = rate_q;
        bus_rdata[CS_LSB +: CSW]   = cs_q;
        bus_rdata[CB_DIR]          = dir_wr;
        bus_rdata[CB_START]        = busy;
      end
      A_LEN:   bus_rdata[LEN_W-1:0]  = len_q;
      A_FIFO:  bus_rdata[WORD_W-1:0] = fifo_rdata;
      A_STAT:  bus_rdata[0] = dir_wr ? fifo_full : fifo_empty;
      A_IMASK: bus_rdata[0] = mask_q;
      A_ISTAT: bus_rdata[0] = istat;
      default: ;
    endcase
  end

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign spi_cs_n[i] = !(cs_act && cs_q == CSW'(i));
  end

  assign irq = istat & ~mask_q;

  spim_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(start_req),
    .push(fifo_push), .wdata(fifo_wdata), .pop(fifo_pop),
    .rdata(fifo_rdata), .full(fifo_full), .empty(fifo_empty)
  );

  spim_rate #(.DIV_BASE(DIV_BASE)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(sh_busy), .code(rate_q), .tick(tick)
  );

  spim_shift #(.BITS(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx(sh_tx), .tick(tick),
    .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .busy(sh_busy),
    .done(sh_done), .rx(sh_rx)
  );
endmodule

// File: rtl/spim_chk.sv
module spim_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           istat,
  input logic           irq,
  input logic           spi_sck,
  input logic [NCS-1:0] spi_cs_n,
  input logic           fifo_push,
  input logic           fifo_full
);
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~spi_cs_n) <= 1); // R6

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sck); // R3

  AST_SELECT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (~spi_cs_n != '0)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_push && fifo_full)); // R8

  AST_END_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> istat); // R10

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> istat); // R10
endmodule

bind spim_master spim_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .istat(istat), .irq(irq),
  .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
  .fifo_push(fifo_push), .fifo_full(fifo_full)
);

// File: tb/spim_master_tb.sv
module spim_master_tb;
  localparam int NCS = 4;
  localparam logic [4:0] A_CTRL = 5'h00, A_DONE = 5'h04, A_LEN = 5'h08,
    A_FIFO = 5'h0C, A_STAT = 5'h10, A_IMASK = 5'h18, A_ISTAT = 5'h1C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic spi_sck, spi_mosi, spi_miso;
  logic [NCS-1:0] spi_cs_n;
  logic irq;

  int n_chk = 0, n_err = 0;
  bit fin = 1'b0;
  logic [7:0] pay [0:63];
  logic [7:0] mon [0:255];
  int mon_n = 0, mon_bits = 0;
  logic [7:0] mon_sr = '0;
  time t_rise = 0, hi_len = 0, t_fall = 0, t_cs_up = 0;
  logic [7:0] sb;

  always #4 clk = ~clk;

  spim_master u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n), .irq(irq)
  );

  function automatic logic [7:0] sbyte(int n);
    return 8'(n * 29 + 3) ^ 8'h5A;
  endfunction

  // slave model: samples MOSI on rise, presents MISO bits MSB first
  always @(posedge spi_sck) begin
    mon_sr = {mon_sr[6:0], spi_mosi};
    t_rise = $time;
    mon_bits = mon_bits + 1;
    if (mon_bits == 8) begin
      mon[mon_n[7:0]] = mon_sr;
      mon_n = mon_n + 1;
      mon_bits = 0;
    end
  end
  always @(negedge spi_sck) begin
    hi_len = $time - t_rise;
    t_fall = $time;
  end
  always @(spi_cs_n) if (spi_cs_n == '1) t_cs_up = $time;
  always_comb sb = sbyte(mon_n);
  assign spi_miso = sb[3'(7 - mon_bits)];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    do bus_read(A_CTRL, v); while (v[15]);
  endtask

  task automatic wait_stat_ok();
    logic [31:0] v;
    do bus_read(A_STAT, v); while (v[0]);
  endtask

  task automatic run_write(input int cs, input int code, input int n);
    logic [31:0] v, w;
    mon_n = 0; mon_bits = 0;
    bus_write(A_LEN, 32'(n));
    bus_write(A_CTRL, 32'h0000_A000 | 32'(cs << 6) | 32'(code));
    bus_read(A_CTRL, v);
    chk(v[15] == 1'b1, "R9 busy after start", v, 32'h8000);
    for (int k = 0; k < (n + 3) / 4; k++) begin
      w = '0;
      for (int b = 0; b < 4; b++)
        if (4 * k + b < n) w[8*b +: 8] = pay[4 * k + b];
      wait_stat_ok();
      bus_write(A_FIFO, w);
    end
    wait_idle();
    chk(mon_n == n, "R3 byte count", 32'(mon_n), 32'(n));
    for (int i = 0; i < n; i++)
      chk(mon[i] == pay[i], "R3 wire byte", 32'(mon[i]), 32'(pay[i]));
    chk(spi_cs_n == ~(NCS'(1) << cs), "R6 select held", 32'(spi_cs_n),
        32'(~(NCS'(1) << cs)));
  endtask

  task automatic run_read(input int cs, input int code, input int n);
    logic [31:0] v, e;
    mon_n = 0; mon_bits = 0;
    bus_write(A_LEN, 32'(n));
    bus_write(A_CTRL, 32'h0000_8000 | 32'(cs << 6) | 32'(code));
    bus_read(A_STAT, v);
    chk(v[0] == 1'b1, "R8 empty flag on receive", v, 32'h1);
    for (int k = 0; k < (n + 3) / 4; k++) begin
      e = '0;
      for (int b = 0; b < 4; b++)
        if (4 * k + b < n) e[8*b +: 8] = sbyte(4 * k + b);
      wait_stat_ok();
      bus_read(A_FIFO, v);
      chk(v == e, "R4 packed word", v, e);
    end
    wait_idle();
    for (int i = 0; i < n; i++)
      chk(mon[i] == 8'h00, "R4 MOSI zero", 32'(mon[i]), 32'h0);
    chk(spi_cs_n == ~(NCS'(1) << cs), "R6 select held", 32'(spi_cs_n),
        32'(~(NCS'(1) << cs)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] w;
    int cs, code, n;
    v = $urandom(32'h5EED_0042);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(spi_cs_n == '1, "R1 selects high", 32'(spi_cs_n), 32'hF);
    chk(!spi_sck && !irq, "R1 sck/irq low", {30'b0, spi_sck, irq}, 32'h0);
    bus_read(A_CTRL, v);
    chk(v == 32'h0, "R1 control zero", v, 32'h0);
    bus_read(A_STAT, v);
    chk(v == 32'h1, "R1 status", v, 32'h1);

    // R2 length width
    bus_write(A_LEN, 32'hFFFF_FFFF);
    bus_read(A_LEN, v);
    chk(v == 32'h001F_FFFF, "R2 length mask", v, 32'h001F_FFFF);

    // directed send, 5 bytes, select 1, code 5
    pay[0] = 8'hA1; pay[1] = 8'h52; pay[2] = 8'hC3; pay[3] = 8'h84; pay[4] = 8'h1F;
    run_write(1, 5, 5);
    bus_read(A_CTRL, v);
    chk(v == 32'h0000_2045, "R2 control fields", v, 32'h0000_2045);

    // receive on same select
    run_read(1, 4, 6);

    // R7 done while idle
    bus_write(A_DONE, 32'h0);
    chk(spi_cs_n == '1, "R7 release on done", 32'(spi_cs_n), 32'hF);

    // R5 rate codes
    pay[0] = 8'h81;
    run_write(0, 3, 1);
    chk(hi_len == 32, "R5 code3 high time", 32'(hi_len / 8), 32'd4);
    run_write(0, 4, 1);
    chk(hi_len == 16, "R5 code4 high time", 32'(hi_len / 8), 32'd2);
    run_write(0, 5, 1);
    chk(hi_len == 8, "R5 code5 high time", 32'(hi_len / 8), 32'd1);
    run_write(0, 7, 1);
    chk(hi_len == 8, "R5 code7 clamps", 32'(hi_len / 8), 32'd1);
    bus_write(A_DONE, 32'h0);

    // R9 restart ignored, R7 deferred done
    mon_n = 0; mon_bits = 0;
    pay[0] = 8'h11; pay[1] = 8'h22; pay[2] = 8'h33; pay[3] = 8'hF4;
    bus_write(A_LEN, 32'd4);
    bus_write(A_CTRL, 32'h0000_A000 | (32'd2 << 6) | 32'd3);
    bus_write(A_CTRL, 32'h0000_8000 | 32'd5);
    chk(spi_cs_n == 4'b1011, "R9 restart ignored select", 32'(spi_cs_n), 32'hB);
    bus_read(A_CTRL, v);
    chk(v[13] == 1'b1, "R9 restart ignored direction", v, 32'h2000);
    bus_write(A_FIFO, 32'hF433_2211);
    bus_write(A_DONE, 32'h0);
    chk(spi_cs_n == 4'b1011, "R7 done deferred", 32'(spi_cs_n), 32'hB);
    wait_idle();
    chk(spi_cs_n == '1, "R7 release after end", 32'(spi_cs_n), 32'hF);
    chk((t_cs_up - t_fall) >= 32, "R7 release gap", 32'(t_cs_up - t_fall), 32'd32);
    chk(mon_n == 4 && mon[3] == 8'hF4, "R9 bytes of kept transfer",
        32'(mon[3]), 32'hF4);

    // R8 full flag on send
    mon_n = 0; mon_bits = 0;
    for (int i = 0; i < 40; i++) pay[i] = 8'($urandom);
    bus_write(A_LEN, 32'd40);
    bus_write(A_CTRL, 32'h0000_A000 | (32'd3 << 6) | 32'd3);
    for (int k = 0; k < 9; k++)
      bus_write(A_FIFO, {pay[4*k+3], pay[4*k+2], pay[4*k+1], pay[4*k]});
    bus_read(A_STAT, v);
    chk(v[0] == 1'b1, "R8 full flag on send", v, 32'h1);
    wait_stat_ok();
    bus_write(A_FIFO, {pay[39], pay[38], pay[37], pay[36]});
    wait_idle();
    chk(mon_n == 40, "R8 all bytes after stall", 32'(mon_n), 32'd40);
    for (int i = 0; i < 40; i++)
      chk(mon[i] == pay[i], "R8 byte after stall", 32'(mon[i]), 32'(pay[i]));

    // R10 interrupt
    chk(irq == 1'b1, "R10 irq at end", 32'(irq), 32'h1);
    bus_write(A_IMASK, 32'h1);
    chk(irq == 1'b0, "R10 masked", 32'(irq), 32'h0);
    bus_write(A_ISTAT, 32'h1);
    bus_write(A_IMASK, 32'h0);
    chk(irq == 1'b0, "R10 cleared", 32'(irq), 32'h0);
    bus_read(A_ISTAT, v);
    chk(v == 32'h0, "R10 status cleared", v, 32'h0);
    bus_write(A_DONE, 32'h0);

    // random mix
    for (int it = 0; it < 10; it++) begin
      cs = int'($urandom % 4);
      code = 3 + int'($urandom % 3);
      n = 1 + int'($urandom % 16);
      for (int i = 0; i < n; i++) pay[i] = 8'($urandom);
      if (it % 2 == 0) run_write(cs, code, n);
      else             run_read(cs, code, n);
      chk(irq == 1'b1, "R10 irq after random transfer", 32'(irq), 32'h1);
      bus_write(A_ISTAT, 32'h1);
      if ($urandom % 2 == 1) begin
        bus_write(A_DONE, 32'h0);
        chk(spi_cs_n == '1, "R7 random release", 32'(spi_cs_n), 32'hF);
      end
    end
    w = 32'h0;
    bus_read(A_STAT, w);

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule